// File: doc/BRIEF.md
# Latching Interrupt Controller

This block combines nine interrupt sources into a single interrupt line. Five of the sources are general-purpose pins that arrive asynchronously. The other four are on-chip flags: a microphone-presence detector, a microphone-short detector, a clock-loop lock indicator and a sequencer-busy flag. Each source first passes through its own polarity step. The sequencer-busy flag is the only source without one. After that step, a conditioned source that is true sets a sticky status bit. A mask register chooses which status bits contribute to the OR that forms the interrupt line. A final inversion sets whether that line is active high or active low.

Software uses a small register port to service the block. Reading the status location returns every latched bit and clears them all in the same cycle. Any source that is still active in that cycle sets its bit again, so no event is lost. The mask location can be read and written. The polarity location is write-only.

Top module: `irq_ctl`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1 (mask location reads 0x1FF), every polarity control is 0 and `irq_out` is 0.
- R2: A status bit is set on the clock edge after its conditioned source is true, and it stays set while no status read happens, even after the source goes away.
- R3: A read with `reg_addr` = 0 returns the status vector, and the block clears it at that edge. Status bit order: bits 0..4 are GPIO pins 0..4, bit 5 is microphone presence, bit 6 is microphone short, bit 7 is loop lock and bit 8 is sequencer busy.
- R4: If a source is active in the same cycle as a status read, its bit is set after that edge. Setting has priority over clearing.
- R5: `irq_out` (with output polarity 0) is the OR of the status bits whose mask bit is 0. A mask bit of 1 removes that source from the OR.
- R6: A masked source still sets and holds its status bit, and a status read returns that bit.
- R7: Polarity location (`reg_addr` = 2) bits 5, 6 and 7 invert microphone presence, microphone short and loop lock. With the invert bit set, a low input sets the status bit.
- R8: Polarity location bits 0..4 invert GPIO pins 0..4.
- R9: Polarity location bit 8 inverts `irq_out`. With bit 8 set, the line is 1 when no enabled bit is latched and 0 when one is.
- R10: A GPIO pin passes through a two-flop synchronizer before its polarity step. A change on the pin reaches `irq_out` on the third rising edge, and it has not reached it after two edges.
- R11: The mask location (`reg_addr` = 1) reads back what was written to it. A write to the status location does not change the status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_pin | input | 5 | Asynchronous general-purpose interrupt pins |
| mic_present | input | 1 | Microphone-presence flag (synchronous) |
| mic_short | input | 1 | Microphone-short flag (synchronous) |
| loop_lock | input | 1 | Clock-loop lock flag (synchronous) |
| seq_busy | input | 1 | Sequencer-busy flag (synchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears status when reg_addr is 0 |
| reg_addr | input | 2 | 0 status, 1 mask, 2 polarity |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for the addressed location |
| irq_out | output | 1 | Combined interrupt line |

## Verification
A one-cycle pulse on an on-chip flag shows the difference between a sticky bit and a bit that follows its level. A source held high across two back-to-back status reads shows whether setting wins over clearing. When sources are masked, the bench looks at the line and at the status value separately, to confirm that masking hides events from the line only. Inverting the polarity with the inputs held idle, and then driving the inputs to their active levels, checks every polarity control on its own source. Cycle-counted GPIO edges fix the synchronizer latency at exactly three edges.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned DEF_GPIO_CNT = 5;
  localparam int unsigned NAMED_CNT    = 4;
  localparam int unsigned LOC_STATUS   = 0;
  localparam int unsigned LOC_MASK     = 1;
  localparam int unsigned LOC_POL      = 2;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [WIDTH-1:0] chain_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
          chain_q[0] <= din;
          for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
      end
      assign dout = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int unsigned GPIO_CNT = 5,
  localparam int unsigned SRC_CNT = GPIO_CNT + irq_ctl_pkg::NAMED_CNT,
  localparam int unsigned INV_W   = SRC_CNT - 1
) (
  input  logic [GPIO_CNT-1:0] gpio_sync,
  input  logic                mic_present,
  input  logic                mic_short,
  input  logic                loop_lock,
  input  logic                seq_busy,
  input  logic [INV_W-1:0]    inv,
  output logic [SRC_CNT-1:0]  event_vec
);
  // the raw level, flipped when its invert control is set
  function automatic logic [INV_W-1:0] apply_pol(input logic [INV_W-1:0] raw,
                                                 input logic [INV_W-1:0] flip);
    return raw ^ flip;
  endfunction

  logic [INV_W-1:0] raw_vec;
  assign raw_vec = {loop_lock, mic_short, mic_present, gpio_sync};
  assign event_vec = {seq_busy, apply_pol(raw_vec, inv)};
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
  parameter int unsigned SRC_CNT = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_CNT-1:0] event_vec,
  input  logic               clr,
  output logic [SRC_CNT-1:0] status_q
);
  // clear applies first, events are ORed on top so that setting wins
  function automatic logic [SRC_CNT-1:0] next_status(input logic [SRC_CNT-1:0] cur,
                                                     input logic [SRC_CNT-1:0] ev,
                                                     input logic wipe);
    return (wipe ? '0 : cur) | ev;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, event_vec, clr);
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
  parameter int unsigned SRC_CNT = 9,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SRC_CNT-1:0] wdata,
  input  logic [SRC_CNT-1:0] status_q,
  output logic [SRC_CNT-1:0] mask_q,
  output logic [SRC_CNT-1:0] pol_q,
  output logic [SRC_CNT-1:0] rdata,
  output logic               status_clr
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(irq_ctl_pkg::LOC_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(irq_ctl_pkg::LOC_MASK);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(irq_ctl_pkg::LOC_POL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pol_q  <= '0;
    end else if (wr_en) begin
      if (addr == A_MASK) mask_q <= wdata;
      if (addr == A_POL)  pol_q  <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_STATUS)    rdata = status_q;
    else if (addr == A_MASK) rdata = mask_q;
  end

  assign status_clr = rd_en && (addr == A_STATUS);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int unsigned GPIO_CNT    = irq_ctl_pkg::DEF_GPIO_CNT,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 2,
  localparam int unsigned SRC_CNT    = GPIO_CNT + irq_ctl_pkg::NAMED_CNT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GPIO_CNT-1:0] gpio_pin,
  input  logic                mic_present,
  input  logic                mic_short,
  input  logic                loop_lock,
  input  logic                seq_busy,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [SRC_CNT-1:0]  reg_wdata,
  output logic [SRC_CNT-1:0]  reg_rdata,
  output logic                irq_out
);
  function automatic logic combine(input logic [SRC_CNT-1:0] st,
                                   input logic [SRC_CNT-1:0] msk,
                                   input logic pol);
    return (|(st & ~msk)) ^ pol;
  endfunction

  logic [GPIO_CNT-1:0] gpio_sync;
  logic [SRC_CNT-1:0]  event_vec;
  logic [SRC_CNT-1:0]  status_q;
  logic [SRC_CNT-1:0]  mask_q;
  logic [SRC_CNT-1:0]  pol_q;
  logic                status_clr;
  logic                out_pol;

  assign out_pol = pol_q[SRC_CNT-1];

  irq_pin_sync #(.WIDTH(GPIO_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(gpio_pin), .dout(gpio_sync));

  irq_src_cond #(.GPIO_CNT(GPIO_CNT)) u_cond (
    .gpio_sync(gpio_sync), .mic_present(mic_present), .mic_short(mic_short),
    .loop_lock(loop_lock), .seq_busy(seq_busy), .inv(pol_q[SRC_CNT-2:0]),
    .event_vec(event_vec));

  irq_status_latch #(.SRC_CNT(SRC_CNT)) u_latch (
    .clk(clk), .rst_n(rst_n), .event_vec(event_vec), .clr(status_clr),
    .status_q(status_q));

  irq_reg_port #(.SRC_CNT(SRC_CNT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .status_q(status_q), .mask_q(mask_q), .pol_q(pol_q),
    .rdata(reg_rdata), .status_clr(status_clr));

  assign irq_out = combine(status_q, mask_q, out_pol);
endmodule

// File: rtl/irq_ctl_checker.sv
module irq_ctl_checker #(
  parameter int unsigned SRC_CNT = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SRC_CNT-1:0] status_q,
  input logic [SRC_CNT-1:0] event_vec,
  input logic [SRC_CNT-1:0] mask_q,
  input logic [SRC_CNT-1:0] rdata,
  input logic               status_clr,
  input logic               out_pol,
  input logic               irq_out
);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !status_clr |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_vec) |=> ((status_q & $past(event_vec)) == $past(event_vec)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && event_vec == '0) |=> (status_q == '0));

  assert_read_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |-> (rdata == status_q));

  assert_all_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> (irq_out == out_pol));

  assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> (irq_out == out_pol));
endmodule

bind irq_ctl irq_ctl_checker #(.SRC_CNT(SRC_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_q(status_q), .event_vec(event_vec),
  .mask_q(mask_q), .rdata(reg_rdata), .status_clr(status_clr),
  .out_pol(out_pol), .irq_out(irq_out));

// File: tb/irq_ctl_test.sv
module irq_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] gpio_pin = '0;
  logic       mic_present = 1'b0, mic_short = 1'b0, loop_lock = 1'b0, seq_busy = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic       irq_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_ctl uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [8:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [8:0] v;
    check("R1 irq after reset", irq_out, 0);
    rd(2'd1, v); check("R1 mask reset", v, 9'h1FF);
    rd(2'd0, v); check("R1 status reset", v, 0);
  endtask

  task automatic t_mask_readback();
    logic [8:0] v;
    wr(2'd1, 9'h0A5); rd(2'd1, v); check("R11 mask readback", v, 9'h0A5);
    wr(2'd1, 9'h000); rd(2'd1, v); check("R11 mask readback zero", v, 0);
  endtask

  task automatic t_sticky();
    logic [8:0] v;
    @(negedge clk); mic_short = 1'b1;
    @(negedge clk); mic_short = 1'b0;
    check("R2 irq after pulse", irq_out, 1);
    idle(5); check("R2 irq holds", irq_out, 1);
    rd(2'd0, v); check("R3 status value short", v, 9'h040);
    check("R3 irq after read", irq_out, 0);
    rd(2'd0, v); check("R3 status cleared", v, 0);
  endtask

  task automatic t_gpio_latency();
    logic [8:0] v;
    @(negedge clk); gpio_pin[2] = 1'b1;
    idle(2); check("R10 not yet after two edges", irq_out, 0);
    idle(1); check("R10 seen after three edges", irq_out, 1);
    gpio_pin[2] = 1'b0;
    idle(4);
    rd(2'd0, v); check("R3 status gpio2", v, 9'h004);
    rd(2'd0, v); check("R3 gpio2 cleared", v, 0);
  endtask

  task automatic t_set_wins();
    logic [8:0] v;
    @(negedge clk); seq_busy = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R4 first read", v, 9'h100);
    check("R4 irq stays", irq_out, 1);
    rd(2'd0, v); check("R4 second read", v, 9'h100);
    seq_busy = 1'b0;
    rd(2'd0, v); check("R4 last pending", v, 9'h100);
    rd(2'd0, v); check("R4 cleared", v, 0);
  endtask

  task automatic t_mask();
    logic [8:0] v;
    wr(2'd1, 9'h0FF);
    @(negedge clk); loop_lock = 1'b1;
    @(negedge clk); loop_lock = 1'b0;
    check("R5 masked source off line", irq_out, 0);
    rd(2'd0, v); check("R6 masked still latched", v, 9'h080);
    @(negedge clk); seq_busy = 1'b1;
    @(negedge clk); seq_busy = 1'b0;
    check("R5 enabled source on line", irq_out, 1);
    rd(2'd0, v); check("R5 status seq", v, 9'h100);
    check("R5 line drops", irq_out, 0);
    wr(2'd1, 9'h000);
  endtask

  task automatic t_named_invert();
    logic [8:0] v;
    wr(2'd2, 9'h0E0);
    idle(2);
    rd(2'd0, v); check("R7 inverted idle inputs", v, 9'h0E0);
    @(negedge clk); mic_present = 1'b1; mic_short = 1'b1; loop_lock = 1'b1;
    idle(2);
    rd(2'd0, v);
    rd(2'd0, v); check("R7 active inputs inverted quiet", v, 0);
    check("R7 line quiet", irq_out, 0);
    wr(2'd2, 9'h000);
    @(negedge clk); mic_present = 1'b0; mic_short = 1'b0; loop_lock = 1'b0;
    rd(2'd0, v); rd(2'd0, v); check("R7 restored", v, 0);
  endtask

  task automatic t_gpio_invert();
    logic [8:0] v;
    wr(2'd2, 9'h01F);
    idle(2);
    rd(2'd0, v); check("R8 inverted gpio idle", v, 9'h01F);
    @(negedge clk); gpio_pin = 5'h1F;
    idle(4);
    rd(2'd0, v);
    rd(2'd0, v); check("R8 gpio high inverted quiet", v, 0);
    @(negedge clk); gpio_pin = 5'h0A;
    idle(4);
    rd(2'd0, v); check("R8 mixed pins", v, 9'h015);
    wr(2'd2, 9'h000);
    @(negedge clk); gpio_pin = '0;
    idle(5);
    rd(2'd0, v); rd(2'd0, v); check("R8 restored", v, 0);
  endtask

  task automatic t_out_pol();
    logic [8:0] v;
    wr(2'd2, 9'h100);
    check("R9 idle level inverted", irq_out, 1);
    @(negedge clk); mic_present = 1'b1;
    @(negedge clk); mic_present = 1'b0;
    check("R9 active low asserted", irq_out, 0);
    rd(2'd0, v); check("R9 status mic", v, 9'h020);
    check("R9 back to idle", irq_out, 1);
    wr(2'd2, 9'h000);
    check("R9 normal idle", irq_out, 0);
  endtask

  task automatic t_status_write();
    logic [8:0] v;
    @(negedge clk); seq_busy = 1'b1;
    @(negedge clk); seq_busy = 1'b0;
    wr(2'd0, 9'h000);
    check("R11 write does not clear line", irq_out, 1);
    wr(2'd0, 9'h0FF);
    rd(2'd0, v); check("R11 status unchanged by writes", v, 9'h100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_mask_readback();
    t_sticky();
    t_gpio_latency();
    t_set_wins();
    t_mask();
    t_named_invert();
    t_gpio_invert();
    t_out_pol();
    t_status_write();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule